// File: doc/BRIEF.md
# Write-Masked Software Reset Bank

This block holds one control bit per reset line of a chip and drives each line straight from its stored bit. Software reaches the bits through a simple write port (byte address, 32-bit data, enable) and a combinational read port. The bits sit in 32-bit registers placed on 4-byte steps, starting at address 0. Reset line `i` lives in register `i / LANES` at bit `i % LANES`.

A build-time parameter picks the register layout. In masked layout each register carries 16 lines in bits [15:0]. Bits [31:16] of a write act as a per-bit enable for the bit 16 places below, so one line can be asserted or released in a single write. No read-modify-write sequence is needed, and no lock is needed between software agents. In plain layout each register carries 32 lines, and a write overwrites the whole register. Software must then read the register first if it wants to change only some of its bits.

There is no state machine: each register is a plain enabled flop bank with one write path. A write changes state at the next rising clock edge. A read returns the current contents in the same cycle.

Top module: `soft_reset_bank`

## Requirements
- R1: While `rst_n` is low, every `rst_out` line is 0 and every read returns 0. This holds immediately, because the reset is asynchronous.
- R2: Masked layout: a write whose data has bit `b` and bit `b+16` both at 1 drives reset line `reg*16+b` to 1 from the next rising edge.
- R3: Masked layout: a write whose data has bit `b+16` at 1 and bit `b` at 0 drives reset line `reg*16+b` to 0 from the next rising edge.
- R4: Masked layout: a stored bit whose enable bit (`b+16`) is 0 in a write keeps its value, whatever bit `b` of the data holds.
- R5: Masked layout: a read returns the 16 stored bits in [15:0] and 0 in [31:16].
- R6: Line `i` sits in the register at byte address `4*(i/LANES)`, bit `i%LANES`. LANES is 16 in masked layout and 32 in plain layout.
- R7: Plain layout: a write stores all 32 data bits into the addressed register at once, and a read returns all 32 stored bits.
- R8: A write to an address that is not a multiple of 4, or that lies at or beyond `4*NUM_REGS`, changes no line. A read at such an address returns 0.
- R9: In the last register, bit positions above the highest implemented line ignore writes and read as 0.
- R10: With `wr_en` low, no line changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low block reset; clears all stored bits |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data (masked layout: [31:16] enables, [15:0] values) |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| rst_out | output | NUM_LINES | Active-high reset lines, one per stored bit |

## Verification
A wrong stored bit shows on its own `rst_out` line on the first rising edge after the faulty write. The same bit shows on `rd_data` as soon as its register is addressed. Each write is therefore followed by a check of the whole line vector and a readback of the written address, in the next low clock phase. This catches a wrong enable pairing, a wrong bit position or a write that lands in the wrong register within one cycle. Out-of-range writes, misaligned writes and writes into unimplemented bits are each followed by the same vector check. Any leakage would then appear as a changed line in that same cycle.

// File: rtl/srb_pkg.sv
package srb_pkg;

    // Lines carried by one register for the chosen layout.
    function automatic int lanes_for(input bit masked);
        return masked ? 16 : 32;
    endfunction

    // Registers needed to hold n lines, rounded up.
    function automatic int regs_for(input int n, input bit masked);
        int l;
        l = lanes_for(masked);
        return (n + l - 1) / l;
    endfunction

endpackage

// File: rtl/srb_addr_decode.sv
module srb_addr_decode #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 3,
    parameter int IDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_REGS);

    logic [WORD_W-1:0] word;

    assign word = addr[ADDR_W-1:2];
    // Only word-aligned addresses inside the bank select a register.
    assign hit  = (addr[1:0] == 2'b00) && (word < LIMIT);
    assign idx  = IDX_W'(word);
endmodule

// File: rtl/srb_reg_slice.sv
module srb_reg_slice #(
    parameter int LANES  = 16,
    parameter int USED   = 16,
    parameter bit MASKED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    output logic [LANES-1:0] q
);
    // Bits above USED do not exist in hardware: they never take a 1.
    localparam logic [LANES-1:0] VALID = LANES'((64'd1 << USED) - 64'd1);

    logic [LANES-1:0] q_r;
    logic [LANES-1:0] q_nxt;

    generate
        if (MASKED) begin : g_masked
            logic [LANES-1:0] en;
            assign en    = wr_data[2*LANES-1:LANES] & VALID;
            assign q_nxt = (q_r & ~en) | (wr_data[LANES-1:0] & en);
        end else begin : g_plain
            assign q_nxt = wr_data[LANES-1:0] & VALID;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (wr_sel) begin
            q_r <= q_nxt;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/srb_read_mux.sv
module srb_read_mux #(
    parameter int LANES    = 16,
    parameter int NUM_REGS = 3,
    parameter int IDX_W    = 2
) (
    input  logic [LANES-1:0] bank [NUM_REGS],
    input  logic [IDX_W-1:0] idx,
    input  logic             hit,
    output logic [31:0]      data
);
    always_comb begin
        data = 32'h0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit && (idx == IDX_W'(k))) begin
                data = 32'(bank[k]);
            end
        end
    end
endmodule

// File: rtl/soft_reset_bank.sv
module soft_reset_bank
    import srb_pkg::*;
#(
    parameter int NUM_LINES = 40,
    parameter bit MASKED    = 1'b1,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    output logic [NUM_LINES-1:0] rst_out
);
    localparam int LANES    = lanes_for(MASKED);
    localparam int NUM_REGS = regs_for(NUM_LINES, MASKED);
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [IDX_W-1:0] w_idx;
    logic             w_hit;
    logic [IDX_W-1:0] r_idx;
    logic             r_hit;
    logic [LANES-1:0] bank_q [NUM_REGS];

    srb_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_wdec (
        .addr (wr_addr),
        .idx  (w_idx),
        .hit  (w_hit)
    );

    srb_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rdec (
        .addr (rd_addr),
        .idx  (r_idx),
        .hit  (r_hit)
    );

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam int LO   = g * LANES;
            localparam int USED = ((NUM_LINES - LO) >= LANES) ? LANES : (NUM_LINES - LO);
            logic sel;
            assign sel = wr_en && w_hit && (w_idx == IDX_W'(g));
            srb_reg_slice #(.LANES(LANES), .USED(USED), .MASKED(MASKED)) u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_sel  (sel),
                .wr_data (wr_data),
                .q       (bank_q[g])
            );
        end
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            assign rst_out[i] = bank_q[i / LANES][i % LANES];
        end
    endgenerate

    srb_read_mux #(.LANES(LANES), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rmux (
        .bank (bank_q),
        .idx  (r_idx),
        .hit  (r_hit),
        .data (rd_data)
    );
endmodule

// File: rtl/soft_reset_bank_chk.sv
module soft_reset_bank_chk
    import srb_pkg::*;
#(
    parameter int NUM_LINES = 40,
    parameter bit MASKED    = 1'b1,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [31:0]          wr_data,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [31:0]          rd_data,
    input logic [NUM_LINES-1:0] rst_out
);
    localparam int LANES  = lanes_for(MASKED);
    localparam int NREG   = regs_for(NUM_LINES, MASKED);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] NREG_W = WORD_W'(NREG);

    logic                 w_ok;
    logic                 r_ok;
    logic [NUM_LINES-1:0] en_vec;
    logic [NUM_LINES-1:0] exp_next;

    assign w_ok = (wr_addr[1:0] == 2'b00) && (wr_addr[ADDR_W-1:2] < NREG_W);
    assign r_ok = (rd_addr[1:0] == 2'b00) && (rd_addr[ADDR_W-1:2] < NREG_W);

    // Per-line view of which line a write may touch and the value it expects.
    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_exp
            localparam int B = i % LANES;
            localparam logic [WORD_W-1:0] RG = WORD_W'(i / LANES);
            logic hit_line;
            assign hit_line = w_ok && (wr_addr[ADDR_W-1:2] == RG);
            if (MASKED) begin : g_m
                assign en_vec[i] = hit_line && wr_data[B + 16];
            end else begin : g_p
                assign en_vec[i] = hit_line;
            end
            assign exp_next[i] = en_vec[i] ? wr_data[B] : rst_out[i];
        end
    endgenerate

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (rst_out == '0 && rd_data == 32'h0));

    // Covers R2, R3 and R7: each written line takes its data bit.
    assert_next_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rst_out == $past(exp_next)));

    assert_keep_unselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((rst_out ^ $past(rst_out)) & ~$past(en_vec)) == '0));

    assert_bad_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !w_ok) |=> $stable(rst_out));

    assert_bad_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_ok |-> (rd_data == 32'h0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rst_out));

    generate
        if (MASKED) begin : g_upper
            assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                rd_data[31:16] == 16'h0);
        end
    endgenerate
endmodule

bind soft_reset_bank soft_reset_bank_chk #(
    .NUM_LINES (NUM_LINES),
    .MASKED    (MASKED),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rst_out (rst_out)
);

// File: tb/soft_reset_bank_tb.sv
module soft_reset_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_en_p = 1'b0;
    logic [7:0]  wr_addr = 8'h0;
    logic [31:0] wr_data = 32'h0;
    logic [7:0]  rd_addr = 8'h0;
    logic [31:0] rd_data, rd_data_p;
    logic [39:0] rst_out, rst_out_p;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    soft_reset_bank #(.NUM_LINES(40), .MASKED(1'b1), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rst_out(rst_out)
    );

    soft_reset_bank #(.NUM_LINES(40), .MASKED(1'b0), .ADDR_W(8)) u_plain (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_p), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_p), .rst_out(rst_out_p)
    );

    // {address, write data, expected 40 lines after the write} for the masked layout.
    localparam logic [79:0] VECS [NV] = '{
        {8'h00, 32'h0001_0001, 40'h00_0000_0001},  // R2 line 0
        {8'h04, 32'h8000_8000, 40'h00_8000_0001},  // R2 line 31
        {8'h08, 32'h00FF_00FF, 40'hFF_8000_0001},  // R2 lines 32..39
        {8'h08, 32'hFFFF_FFFF, 40'hFF_8000_0001},  // R9 unimplemented bits
        {8'h00, 32'h0001_0000, 40'hFF_8000_0000},  // R3 release line 0
        {8'h00, 32'h0000_FFFF, 40'hFF_8000_0000},  // R4 no enables
        {8'h04, 32'h0FF0_0F30, 40'hFF_8F30_0000},  // R4 partial enables
        {8'h0C, 32'hFFFF_FFFF, 40'hFF_8F30_0000},  // R8 beyond bank
        {8'h02, 32'hFFFF_FFFF, 40'hFF_8F30_0000},  // R8 misaligned
        {8'h08, 32'h0081_0000, 40'h7E_8F30_0000},  // R3 lines 32 and 39
        {8'h04, 32'hFFFF_0000, 40'h7E_0000_0000}   // R3 clear register 1
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Masked-layout read value predicted from the line vector.
    function automatic logic [31:0] exp_rd_m(input logic [7:0] a, input logic [39:0] s);
        logic [47:0] ext;
        ext = {8'h0, s};
        if (a[1:0] != 2'b00 || a[7:2] >= 6'd3) return 32'h0;
        return {16'h0, ext[a[7:2]*16 +: 16]};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit plain);
        @(negedge clk);
        wr_addr = a;
        wr_data = d;
        if (plain) wr_en_p = 1'b1; else wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wr_en_p = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: state held in reset
        #(CLK_PERIOD * 2 + 1);
        check("R1 lines in reset", 64'(rst_out), 64'h0);
        check("R1 plain lines in reset", 64'(rst_out_p), 64'h0);
        rd_addr = 8'h04;
        #1;
        check("R1 read in reset", 64'(rd_data), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic [39:0] e;
            {a, d, e} = VECS[v];
            wr(a, d, 1'b0);
            check($sformatf("R2 R3 R4 vector %0d lines", v), 64'(rst_out), 64'(e));
            rd_addr = a;
            #1;
            check($sformatf("R5 R8 vector %0d readback", v), 64'(rd_data), 64'(exp_rd_m(a, e)));
        end

        // R6: line 17 maps to register 1 (address 4), bit 1
        wr(8'h04, 32'h0002_0002, 1'b0);
        check("R6 line 17 mapping", 64'(rst_out), 64'h7E_0002_0000);
        rd_addr = 8'h08;
        #1;
        check("R9 R5 last register read", 64'(rd_data), 64'h0000_007E);

        // R10: idle bus with busy data
        @(negedge clk);
        wr_addr = 8'h04;
        wr_data = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        #1;
        check("R10 idle hold", 64'(rst_out), 64'h7E_0002_0000);

        // R1: reset in mid-run clears at once
        rst_n = 1'b0;
        #1;
        check("R1 async clear", 64'(rst_out), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: plain layout writes and reads whole words
        wr(8'h00, 32'hA5A5_1234, 1'b1);
        check("R7 plain word write", 64'(rst_out_p), 64'h00_A5A5_1234);
        rd_addr = 8'h00;
        #1;
        check("R7 plain readback", 64'(rd_data_p), 64'hA5A5_1234);
        check("R10 masked untouched by plain strobe", 64'(rst_out), 64'h0);
        wr(8'h00, 32'h0000_0001, 1'b1);
        check("R7 plain overwrite", 64'(rst_out_p), 64'h00_0000_0001);
        // R9 / R6: plain register 1 holds lines 32..39 only
        wr(8'h04, 32'hFFFF_FFFF, 1'b1);
        check("R6 R9 plain high lines", 64'(rst_out_p), 64'hFF_0000_0001);
        rd_addr = 8'h04;
        #1;
        check("R9 plain unimplemented read", 64'(rd_data_p), 64'h0000_00FF);
        // R8: plain write beyond bank
        wr(8'h08, 32'h0000_0000, 1'b1);
        check("R8 plain out of range write", 64'(rst_out_p), 64'hFF_0000_0001);
        rd_addr = 8'h08;
        #1;
        check("R8 plain out of range read", 64'(rd_data_p), 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule